// File: doc/BRIEF.md
# Masked Interrupt Controller with Halt Wake

This block gathers single-cycle request pulses from up to 32 numbered peripheral sources into a pending register. It decides, against a per-source enable mask and a global master enable, when the CPU should be interrupted. Software programs the master enable and the enable mask through a small write port. The same port acknowledges pending sources by writing ones.

Each write to the enable mask or the master enable re-evaluates the request against the current pending bits. So does every arrival of an enabled source. A positive evaluation is held as a deferred request until the CPU's interrupt-disable input is low, and is then delivered as a one-cycle IRQ pulse with the mask of causes.

A separate power path tracks a halt state. The CPU enters it through a halt request. Any arriving source that is enabled in the mask leaves it, even when the master enable is zero.

The delivery path is a three-state machine:
- `DLV_IDLE`: nothing is queued. It goes to `DLV_HELD` when an evaluation finds enabled pending sources with the master enable on.
- `DLV_HELD`: a request is queued and waits. It goes to `DLV_SIGNAL` on a cycle where the interrupt-disable input is low.
- `DLV_SIGNAL`: the IRQ is asserted for this one cycle. It goes back to `DLV_HELD` if a new request was queued meanwhile, otherwise to `DLV_IDLE`.

The power path has two states:
- `PWR_RUN`: the CPU is running. It goes to `PWR_HALT` on a halt request.
- `PWR_HALT`: the CPU is halted. It goes back to `PWR_RUN` on the arrival of an enabled source.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the pending, enable and master-enable registers are zero, `irq_o`, `wake_o` and `halted_o` are low, and `irq_cause_o` is zero.
- R2: A pulse on source n sets pending bit n at the next clock edge, whether or not the source is enabled. Sources 0 to 15 fill the low half-word and sources 16 to 31 fill the high half-word.
- R3: A write with select 2 clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. A raise of the same source in the same cycle wins over the clear.
- R4: No IRQ is queued while the master enable is zero or while (enable AND pending) is zero.
- R5: A write with select 1 loads the enable mask and re-evaluates at once. If the master enable is nonzero and a newly enabled source is already pending, `irq_o` pulses two clock edges after the write cycle.
- R6: A write with select 0 loads the master enable from data bits [15:0]. A nonzero value while an enabled source is pending makes `irq_o` pulse two clock edges after the write cycle.
- R7: While `cpu_int_dis_i` is high a queued request is held and `irq_o` stays low. It is delivered at the first clock edge with `cpu_int_dis_i` low and then cleared.
- R8: The arrival of a source whose enable bit is set clears the halt state and pulses `wake_o` at the next edge, regardless of the master enable. A disabled source does neither.
- R9: `halt_req_i` sets the halt state at the next edge. A same-cycle wake wins over it.
- R10: `irq_o` is a registered one-cycle pulse per delivered request. `irq_cause_o` holds the enabled-pending mask that was delivered.
- R11: A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_raise_i | input | 32 | One-cycle request pulse per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 master enable, 1 enable mask, 2 pending acknowledge, 3 none |
| wr_data_i | input | 32 | Write data |
| cpu_int_dis_i | input | 1 | CPU interrupt-disable bit; defers delivery while high |
| halt_req_i | input | 1 | CPU requests the halt state |
| irq_o | output | 1 | One-cycle interrupt request to the CPU |
| irq_cause_o | output | 32 | Enabled-pending mask of the last delivered request |
| wake_o | output | 1 | One-cycle pulse when an enabled source arrives |
| halted_o | output | 1 | Halt state |
| pending_o | output | 32 | Pending register |
| enable_o | output | 32 | Enable mask register |
| master_o | output | 16 | Master enable register |

## Verification
A vector table steps the controller through interleaved source arrivals, mask writes, master-enable writes and acknowledges. This tells apart the three triggers that may queue a request from the acknowledge write, which must not. Arrivals on the low and high half-words, with the master enable first at zero and later nonzero, separate the masking conditions from plain latching. A combined acknowledge-and-raise on one source shows which of the two wins. Directed sequences hold the interrupt-disable input high across several cycles to expose early delivery. They also drive enabled and disabled arrivals during halt with the master enable off, which shows that wake is independent of IRQ masking.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

    typedef enum logic [1:0] {
        REG_MASTER = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        DLV_IDLE   = 2'd0,
        DLV_HELD   = 2'd1,
        DLV_SIGNAL = 2'd2
    } dlv_state_e;

    typedef enum logic {
        PWR_RUN  = 1'b0,
        PWR_HALT = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/irqw_regs.sv
module irqw_regs
    import irqw_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int MASTER_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [NUM_SRC-1:0]  wr_data_i,
    output logic [NUM_SRC-1:0]  pend_q,
    output logic [NUM_SRC-1:0]  en_q,
    output logic [MASTER_W-1:0] master_q,
    output logic [NUM_SRC-1:0]  live_nx_o,
    output logic                master_on_nx_o,
    output logic                eval_o,
    output logic                hit_o
);

    reg_sel_e             sel;
    logic                 wr_master;
    logic                 wr_enable;
    logic                 wr_ack;
    logic [NUM_SRC-1:0]   pend_nx;
    logic [NUM_SRC-1:0]   en_nx;
    logic [MASTER_W-1:0]  master_nx;

    always_comb begin
        sel       = reg_sel_e'(wr_sel_i);
        wr_master = 1'b0;
        wr_enable = 1'b0;
        wr_ack    = 1'b0;
        if (wr_en_i) begin
            unique case (sel)
                REG_MASTER: wr_master = 1'b1;
                REG_ENABLE: wr_enable = 1'b1;
                REG_ACK:    wr_ack    = 1'b1;
                REG_NONE:   ;
            endcase
        end
    end

    // one pending cell per source: raise wins over acknowledge
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
        assign pend_nx[i] = src_i[i] | (pend_q[i] & ~(wr_ack & wr_data_i[i]));
    end

    assign en_nx     = wr_enable ? wr_data_i : en_q;
    assign master_nx = wr_master ? wr_data_i[MASTER_W-1:0] : master_q;

    assign live_nx_o      = en_nx & pend_nx;
    assign master_on_nx_o = |master_nx;
    assign hit_o          = |(src_i & en_nx);
    assign eval_o         = wr_enable | wr_master | hit_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            en_q     <= '0;
            master_q <= '0;
        end else begin
            pend_q   <= pend_nx;
            en_q     <= en_nx;
            master_q <= master_nx;
        end
    end

    // R2
    raise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_i) |=> ((pend_q & $past(src_i)) == $past(src_i)));

    // R3
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == 2'd2) |=> (($past(pend_q) & ~pend_q) == '0));

    // R11
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd3) |=> ($stable(en_q) && $stable(master_q)));

endmodule

// File: rtl/irqw_deliver.sv
module irqw_deliver
    import irqw_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eval_i,
    input  logic               master_on_i,
    input  logic [NUM_SRC-1:0] live_i,
    input  logic               cpu_int_dis_i,
    output logic               irq_o,
    output logic [NUM_SRC-1:0] cause_o
);

    dlv_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] defer_q, defer_d;
    logic [NUM_SRC-1:0] cause_d;
    logic               fire;
    logic               take;

    assign fire = eval_i & master_on_i & (|live_i);
    assign take = (state_q == DLV_HELD) & ~cpu_int_dis_i;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLV_IDLE:   if (fire) state_d = DLV_HELD;
            DLV_HELD:   if (!cpu_int_dis_i) state_d = DLV_SIGNAL;
            DLV_SIGNAL: state_d = (fire || (|defer_q)) ? DLV_HELD : DLV_IDLE;
            default:    state_d = DLV_IDLE;
        endcase
    end

    always_comb begin
        defer_d = defer_q;
        cause_d = cause_o;
        if (take) begin
            cause_d = defer_q;
            defer_d = '0;
        end
        if (fire) begin
            defer_d = live_i;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DLV_IDLE;
            defer_q <= '0;
        end else begin
            state_q <= state_d;
            defer_q <= defer_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o   <= 1'b0;
            cause_o <= '0;
        end else begin
            irq_o   <= (state_d == DLV_SIGNAL);
            cause_o <= cause_d;
        end
    end

    // R7
    irq_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int_dis_i |=> !irq_o);

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R4
    no_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DLV_IDLE && !master_on_i) |=> (state_q == DLV_IDLE));

endmodule

// File: rtl/irqw_wake.sv
module irqw_wake
    import irqw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic halt_req_i,
    output logic wake_o,
    output logic halted_o
);

    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:  if (halt_req_i && !hit_i) state_d = PWR_HALT;
            PWR_HALT: if (hit_i) state_d = PWR_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_o <= 1'b0;
        end else begin
            wake_o <= hit_i;
        end
    end

    assign halted_o = (state_q == PWR_HALT);

    // R8
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !halted_o);

    // R9
    halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_i && !hit_i) |=> halted_o);

endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import irqw_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int MASTER_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_raise_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [NUM_SRC-1:0]  wr_data_i,
    input  logic                cpu_int_dis_i,
    input  logic                halt_req_i,
    output logic                irq_o,
    output logic [NUM_SRC-1:0]  irq_cause_o,
    output logic                wake_o,
    output logic                halted_o,
    output logic [NUM_SRC-1:0]  pending_o,
    output logic [NUM_SRC-1:0]  enable_o,
    output logic [MASTER_W-1:0] master_o
);

    logic [NUM_SRC-1:0] live_nx;
    logic               master_on_nx;
    logic               eval;
    logic               hit;

    irqw_regs #(
        .NUM_SRC  (NUM_SRC),
        .MASTER_W (MASTER_W)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .src_i          (src_raise_i),
        .wr_en_i        (wr_en_i),
        .wr_sel_i       (wr_sel_i),
        .wr_data_i      (wr_data_i),
        .pend_q         (pending_o),
        .en_q           (enable_o),
        .master_q       (master_o),
        .live_nx_o      (live_nx),
        .master_on_nx_o (master_on_nx),
        .eval_o         (eval),
        .hit_o          (hit)
    );

    irqw_deliver #(
        .NUM_SRC (NUM_SRC)
    ) u_deliver (
        .clk           (clk),
        .rst_n         (rst_n),
        .eval_i        (eval),
        .master_on_i   (master_on_nx),
        .live_i        (live_nx),
        .cpu_int_dis_i (cpu_int_dis_i),
        .irq_o         (irq_o),
        .cause_o       (irq_cause_o)
    );

    irqw_wake u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .halt_req_i (halt_req_i),
        .wake_o     (wake_o),
        .halted_o   (halted_o)
    );

    // R10
    cause_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_cause_o != '0));

endmodule

// File: tb/irq_wake_ctrl_bench.sv
`timescale 1ns/1ps
module irq_wake_ctrl_bench;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sel;
        logic [31:0] data;
        logic [31:0] src;
        logic        exp_irq;
        logic [31:0] exp_pend;
        logic [31:0] exp_cause;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 32'h0,        32'h0000_0008, 1'b0, 32'h0000_0008, 32'h0},        // R2 low half, R4 not enabled
        '{1'b1, 2'd1, 32'h8,        32'h0,         1'b0, 32'h0000_0008, 32'h0},        // R4 master zero
        '{1'b1, 2'd0, 32'h1,        32'h0,         1'b1, 32'h0000_0008, 32'h8},        // R6
        '{1'b0, 2'd0, 32'h0,        32'h0010_0000, 1'b0, 32'h0010_0008, 32'h0},        // R2 high half
        '{1'b1, 2'd1, 32'h0010_0008,32'h0,         1'b1, 32'h0010_0008, 32'h0010_0008},// R5
        '{1'b1, 2'd2, 32'h8,        32'h0,         1'b0, 32'h0010_0000, 32'h0},        // R3 clear
        '{1'b1, 2'd3, 32'hFFFF_FFFF,32'h0,         1'b0, 32'h0010_0000, 32'h0},        // R11
        '{1'b1, 2'd0, 32'h0,        32'h0,         1'b0, 32'h0010_0000, 32'h0},        // R4 master off
        '{1'b0, 2'd0, 32'h0,        32'h0010_0000, 1'b0, 32'h0010_0000, 32'h0},        // R4
        '{1'b1, 2'd0, 32'h2,        32'h0,         1'b1, 32'h0010_0000, 32'h0010_0000},// R6
        '{1'b1, 2'd2, 32'h0010_0000,32'h0010_0000, 1'b1, 32'h0010_0000, 32'h0010_0000},// R3 raise wins
        '{1'b1, 2'd2, 32'hFFFF_FFFF,32'h0,         1'b0, 32'h0,         32'h0}         // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_raise = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        int_dis = 1'b0;
    logic        halt_req = 1'b0;
    logic        irq;
    logic [31:0] cause;
    logic        wake;
    logic        halted;
    logic [31:0] pend;
    logic [31:0] en;
    logic [15:0] master;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_wake_ctrl u_irq_wake_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_raise_i   (src_raise),
        .wr_en_i       (wr_en),
        .wr_sel_i      (wr_sel),
        .wr_data_i     (wr_data),
        .cpu_int_dis_i (int_dis),
        .halt_req_i    (halt_req),
        .irq_o         (irq),
        .irq_cause_o   (cause),
        .wake_o        (wake),
        .halted_o      (halted),
        .pending_o     (pend),
        .enable_o      (en),
        .master_o      (master)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pending", pend, 32'h0);
        check("R1 enable", en, 32'h0);
        check("R1 master", {16'h0, master}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 wake", {31'h0, wake}, 32'h0);
        check("R1 halted", {31'h0, halted}, 32'h0);
        check("R1 cause", cause, 32'h0);

        // table: R2 R3 R4 R5 R6 R10 R11
        for (int i = 0; i < NV; i++) begin
            wr_en     = VECS[i].wr;
            wr_sel    = VECS[i].sel;
            wr_data   = VECS[i].data;
            src_raise = VECS[i].src;
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0; src_raise = '0; wr_sel = '0;
            check($sformatf("vec%0d R2/R3 pending", i), pend, VECS[i].exp_pend);
            cyc();
            check($sformatf("vec%0d R4/R5/R6 irq", i), {31'h0, irq}, {31'h0, VECS[i].exp_irq});
            if (VECS[i].exp_irq)
                check($sformatf("vec%0d R10 cause", i), cause, VECS[i].exp_cause);
            cyc();
            check($sformatf("vec%0d R10 pulse end", i), {31'h0, irq}, 32'h0);
        end
        // R11 registers untouched by select 3
        check("R11 enable", en, 32'h0010_0008);
        check("R11 master", {16'h0, master}, 32'h2);

        // R7 deferral while interrupt-disable is high
        int_dis = 1'b1;
        src_raise = 32'h0010_0000;
        cyc();
        src_raise = '0;
        for (int k = 0; k < 5; k++) begin
            cyc();
            check("R7 held", {31'h0, irq}, 32'h0);
        end
        int_dis = 1'b0;
        cyc();
        check("R7 delivered", {31'h0, irq}, 32'h1);
        check("R7 cause", cause, 32'h0010_0000);
        cyc();
        check("R7 cleared", {31'h0, irq}, 32'h0);
        cyc();
        check("R7 no repeat", {31'h0, irq}, 32'h0);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'hFFFF_FFFF;
        cyc();
        wr_en = 1'b0; wr_data = '0;
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0;
        cyc();
        wr_en = 1'b0; wr_sel = '0;

        // R9 halt entry
        halt_req = 1'b1;
        cyc();
        halt_req = 1'b0;
        check("R9 halted", {31'h0, halted}, 32'h1);
        // R8 disabled source does not wake
        src_raise = 32'h0000_0020;
        cyc();
        src_raise = '0;
        check("R8 disabled stays halted", {31'h0, halted}, 32'h1);
        check("R8 disabled no wake", {31'h0, wake}, 32'h0);
        // R8 enabled source wakes with master zero
        src_raise = 32'h0000_0008;
        cyc();
        src_raise = '0;
        check("R8 wake pulse", {31'h0, wake}, 32'h1);
        check("R8 halt cleared", {31'h0, halted}, 32'h0);
        cyc();
        check("R8 wake ends", {31'h0, wake}, 32'h0);
        check("R4 no irq master zero", {31'h0, irq}, 32'h0);
        // R9 same-cycle wake wins
        halt_req = 1'b1;
        src_raise = 32'h0000_0008;
        cyc();
        halt_req = 1'b0;
        src_raise = '0;
        check("R9 wake wins", {31'h0, halted}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule